// File: doc/BRIEF.md
# Static memory access sequencer

This block runs single read and write transfers to external asynchronous memory banks: ROM, SRAM, flash or peripherals mapped into memory. A requester presents a bank number, an address, a direction, write data and byte enables for one cycle. The sequencer then walks the memory pins through a fixed pattern:

- drive the address and the one chip select;
- hold the strobe for a counted number of wait states;
- finish the access;
- report completion with the read data.

Each bank has its own settings:

- a write-protect bit;
- a page-mode bit;
- an extended-wait bit;
- a 5-bit read wait field;
- a 5-bit write wait field.

One 10-bit extended wait field is shared by all banks. A bank running in extended-wait mode uses that shared field, scaled by 16, for both directions. This covers devices that need thousands of wait states.

Some requests are refused with a two-cycle error response, and no pin activity takes place:

- a write to a write-protected bank;
- any access to a bank that has page mode and extended wait both set.

The states are named as follows:

- IDLE waits for a request.
- SETUP drives chip select and address.
- WAIT counts wait states with the strobe active.
- DONE releases the write strobe or samples read data.
- RECOVER holds every chip select inactive and raises ready.
- ERR1 and ERR2 form the error response.

The transitions are:

- IDLE→SETUP on an accepted legal request.
- IDLE→ERR1 on a refused request.
- SETUP→WAIT.
- WAIT→WAIT while the count runs.
- WAIT→DONE on the last wait state.
- DONE→RECOVER.
- RECOVER→IDLE.
- ERR1→ERR2.
- ERR2→IDLE.

Top module: `async_mem_sequencer`

## Requirements
- R1: During and right after reset, all chip selects, write enable and output enable are high (inactive), and ready and error are low.
- R2: A request is accepted only in IDLE. A legal normal-mode read with read wait field N has W = N+1 wait states (1 to 32). Its pattern is one SETUP cycle, W WAIT cycles, one DONE cycle, then ready in the cycle after DONE, which is W+3 cycles after the request cycle.
- R3: A legal write follows the R2 pattern with W = write wait field + 1. Write enable (active low) is low exactly in the W WAIT cycles. Output enable stays high for the whole write. Address and data are still driven in the cycle after write enable rises.
- R4: For reads, output enable is low in WAIT and DONE. The memory data present in the DONE cycle appears on rsp_rdata while ready is high.
- R5: When a bank's extended-wait bit is set, both reads and writes use W = shared field × 16. A shared field of 0 gives W = 1. The bank's read and write wait fields then have no effect. A field of 1023 gives 16368 wait states.
- R6: A write to a bank whose write-protect bit is 1 produces no chip select, write enable or output enable activity. The error is high for two cycles, with ready low in the first and high in the second, starting the cycle after the request. A read of a protected bank proceeds normally.
- R7: A bank with page bit and extended-wait bit both set is illegal. Reads and writes to it get the R6 error response and no memory cycle.
- R8: Only the chip select of the requested bank (bit index = bank number) goes low. Address, write data and active-low byte enables (inverted request enables for writes, all low for reads) stay constant while it is low.
- R9: A request presented while a transfer or error response is in progress is ignored and does not alter the running transfer.
- R10: In the ready cycle every chip select is high. After it, the block is back in IDLE with all strobes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in IDLE only |
| req_bank | input | BANK_W | Target bank number |
| req_addr | input | ADDR_W | Memory address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables, active high |
| cfg_wprot | input | NUM_BANKS | Per-bank write protect |
| cfg_page | input | NUM_BANKS | Per-bank page-mode bit |
| cfg_xwait_en | input | NUM_BANKS | Per-bank extended-wait enable |
| cfg_rd_wait | input | NUM_BANKS*NWAIT_W | Per-bank read wait fields, bank b at bits b*NWAIT_W upward |
| cfg_wr_wait | input | NUM_BANKS*NWAIT_W | Per-bank write wait fields, same layout |
| cfg_xwait_cnt | input | XWAIT_W | Shared extended wait field, units of 16 |
| rsp_ready | output | 1 | Transfer finished / second error phase |
| rsp_error | output | 1 | Error response |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | NUM_BANKS | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be_n | output | BE_W | Byte lane enables, active low |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
A state that is wrong by one step shows at the pins in the same cycle. The strobes are decoded straight from the state, so a wrong step puts chip select, output enable or write enable out of line with the bench's cycle model, and the per-cycle comparison reports it at once. A wait counter loaded with the wrong length shows no error until the end of the wait. It surfaces as DONE and ready arriving early or late, at the first cycle where the model expects the edge. A corrupted request latch, or a request taken while busy, changes mem_addr, mem_be_n or the chip select pattern during the running access.

// File: rtl/amseq_pkg.sv
`timescale 1ns/1ps
package amseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_DONE,
        ST_RECOVER,
        ST_ERR1,
        ST_ERR2
    } amseq_state_e;

endpackage

// File: rtl/amseq_cfg_select.sv
`timescale 1ns/1ps
module amseq_cfg_select #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int NWAIT_W   = 5,
    parameter int XWAIT_W   = 10,
    parameter int XSCALE_SH = 4,
    parameter int CNT_W     = 14
) (
    input  logic [BANK_W-1:0]            bank,
    input  logic                         write,
    input  logic [NUM_BANKS-1:0]         wprot,
    input  logic [NUM_BANKS-1:0]         page,
    input  logic [NUM_BANKS-1:0]         xwait_en,
    input  logic [NUM_BANKS*NWAIT_W-1:0] rd_wait,
    input  logic [NUM_BANKS*NWAIT_W-1:0] wr_wait,
    input  logic [XWAIT_W-1:0]           xwait_cnt,
    output logic                         reject,
    output logic [CNT_W-1:0]             wait_len
);

    logic             sel_wp;
    logic             sel_pg;
    logic             sel_xw;
    logic [NWAIT_W-1:0] sel_field;
    logic [CNT_W-1:0] ext_len;
    logic [CNT_W-1:0] nrm_len;

    always_comb begin
        sel_wp    = wprot[bank];
        sel_pg    = page[bank];
        sel_xw    = xwait_en[bank];
        sel_field = write ? wr_wait[bank*NWAIT_W +: NWAIT_W]
                          : rd_wait[bank*NWAIT_W +: NWAIT_W];
        nrm_len   = CNT_W'(sel_field) + CNT_W'(1);
        ext_len   = CNT_W'(xwait_cnt) << XSCALE_SH;
        if (ext_len == '0) begin
            ext_len = CNT_W'(1);
        end
        wait_len  = sel_xw ? ext_len : nrm_len;
        reject    = (sel_pg && sel_xw) || (write && sel_wp);
    end

endmodule

// File: rtl/amseq_wait_timer.sv
`timescale 1ns/1ps
module amseq_wait_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (run && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign last = (remain == CNT_W'(1));

endmodule

// File: rtl/async_mem_sequencer.sv
`timescale 1ns/1ps
module async_mem_sequencer
    import amseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int NWAIT_W   = 5,
    parameter int XWAIT_W   = 10,
    parameter int XSCALE_SH = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int BE_W     = DATA_W / 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [BANK_W-1:0]            req_bank,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic                         req_write,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic [BE_W-1:0]              req_be,
    input  logic [NUM_BANKS-1:0]         cfg_wprot,
    input  logic [NUM_BANKS-1:0]         cfg_page,
    input  logic [NUM_BANKS-1:0]         cfg_xwait_en,
    input  logic [NUM_BANKS*NWAIT_W-1:0] cfg_rd_wait,
    input  logic [NUM_BANKS*NWAIT_W-1:0] cfg_wr_wait,
    input  logic [XWAIT_W-1:0]           cfg_xwait_cnt,
    output logic                         rsp_ready,
    output logic                         rsp_error,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic [NUM_BANKS-1:0]         mem_cs_n,
    output logic                         mem_oe_n,
    output logic                         mem_we_n,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic [BE_W-1:0]              mem_be_n,
    input  logic [DATA_W-1:0]            mem_rdata
);

    localparam int XLEN_W = XWAIT_W + XSCALE_SH;
    localparam int CNT_W  = (XLEN_W > NWAIT_W + 1) ? XLEN_W : NWAIT_W + 1;

    amseq_state_e state, state_nx;

    logic [BANK_W-1:0] lat_bank;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic [DATA_W-1:0] lat_wdata;
    logic [BE_W-1:0]   lat_be;
    logic [DATA_W-1:0] rdata_q;

    logic             reject;
    logic [CNT_W-1:0] wait_len;
    logic             accept;
    logic             wait_last;
    logic             cs_act;

    assign accept = (state == ST_IDLE) && req_valid;

    amseq_cfg_select #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .NWAIT_W   (NWAIT_W),
        .XWAIT_W   (XWAIT_W),
        .XSCALE_SH (XSCALE_SH),
        .CNT_W     (CNT_W)
    ) u_cfg (
        .bank      (req_bank),
        .write     (req_write),
        .wprot     (cfg_wprot),
        .page      (cfg_page),
        .xwait_en  (cfg_xwait_en),
        .rd_wait   (cfg_rd_wait),
        .wr_wait   (cfg_wr_wait),
        .xwait_cnt (cfg_xwait_cnt),
        .reject    (reject),
        .wait_len  (wait_len)
    );

    amseq_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_len),
        .run      (state == ST_WAIT),
        .last     (wait_last)
    );

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_bank  <= '0;
            lat_addr  <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
            lat_be    <= '0;
            rdata_q   <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lat_bank  <= req_bank;
                lat_addr  <= req_addr;
                lat_write <= req_write;
                lat_wdata <= req_wdata;
                lat_be    <= req_be;
            end
            if (state == ST_DONE && !lat_write) begin
                rdata_q <= mem_rdata;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = reject ? ST_ERR1 : ST_SETUP;
            ST_SETUP:   state_nx = ST_WAIT;
            ST_WAIT:    if (wait_last) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_RECOVER;
            ST_RECOVER: state_nx = ST_IDLE;
            ST_ERR1:    state_nx = ST_ERR2;
            ST_ERR2:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        cs_act    = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        rsp_ready = 1'b0;
        rsp_error = 1'b0;
        unique case (state)
            ST_IDLE: begin end
            ST_SETUP: cs_act = 1'b1;
            ST_WAIT: begin
                cs_act   = 1'b1;
                mem_we_n = !lat_write;
                mem_oe_n = lat_write;
            end
            ST_DONE: begin
                cs_act   = 1'b1;
                mem_oe_n = lat_write;
            end
            ST_RECOVER: rsp_ready = 1'b1;
            ST_ERR1:    rsp_error = 1'b1;
            ST_ERR2: begin
                rsp_error = 1'b1;
                rsp_ready = 1'b1;
            end
            default: begin end
        endcase
    end

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_cs
            assign mem_cs_n[gb] = !(cs_act && (lat_bank == BANK_W'(gb)));
        end
    endgenerate

    assign mem_addr  = lat_addr;
    assign mem_wdata = lat_wdata;
    assign mem_be_n  = lat_write ? ~lat_be : '0;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/amseq_checker.sv
`timescale 1ns/1ps
module amseq_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] mem_cs_n,
    input logic                 mem_we_n,
    input logic                 mem_oe_n,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 rsp_ready,
    input logic                 rsp_error
);

    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n)); // R8

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !(&mem_cs_n)); // R8

    AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R3

    AST_WE_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!(&mem_cs_n) && $stable(mem_addr))); // R3

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (&mem_cs_n && mem_we_n && mem_oe_n)); // R6

    AST_ERR_TWO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_error && !rsp_ready) |=> (rsp_error && rsp_ready)); // R6

    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> &mem_cs_n); // R10

endmodule

bind async_mem_sequencer amseq_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) u_amseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .rsp_ready (rsp_ready),
    .rsp_error (rsp_error)
);

// File: tb/async_mem_sequencer_test.sv
`timescale 1ns/1ps
module async_mem_sequencer_test;

    localparam int NB = 4;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int BW = 2;
    localparam int EW = DW / 8;

    typedef struct packed {
        logic [NB-1:0] cs_n;
        logic          we_n;
        logic          oe_n;
        logic          rdy;
        logic          err;
        logic          act;
        logic          rd_chk;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [EW-1:0] req_be = '0;
    logic [NB-1:0] cfg_wprot = '0;
    logic [NB-1:0] cfg_page = '0;
    logic [NB-1:0] cfg_xwait_en = '0;
    logic [NB*5-1:0] cfg_rd_wait = '0;
    logic [NB*5-1:0] cfg_wr_wait = '0;
    logic [9:0] cfg_xwait_cnt = '0;
    logic rsp_ready, rsp_error;
    logic [DW-1:0] rsp_rdata;
    logic [NB-1:0] mem_cs_n;
    logic mem_oe_n, mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [EW-1:0] mem_be_n;
    logic [DW-1:0] mem_rdata = '0;

    always #2 clk = ~clk;

    async_mem_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_be(req_be), .cfg_wprot(cfg_wprot), .cfg_page(cfg_page),
        .cfg_xwait_en(cfg_xwait_en), .cfg_rd_wait(cfg_rd_wait),
        .cfg_wr_wait(cfg_wr_wait), .cfg_xwait_cnt(cfg_xwait_cnt),
        .rsp_ready(rsp_ready), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be_n(mem_be_n),
        .mem_rdata(mem_rdata)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit run_chk = 1'b0;
    bit finished = 1'b0;

    exp_t  expq[$];
    string tagq[$];

    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic [EW-1:0] cur_be_n;
    logic          cur_write;
    logic [DW-1:0] cur_rdata;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic [NB-1:0] cs_n, input logic we_n, input logic oe_n,
                                input logic rdy, input logic err, input logic act,
                                input logic rd_chk);
        exp_t e;
        e.cs_n = cs_n; e.we_n = we_n; e.oe_n = oe_n; e.rdy = rdy;
        e.err = err; e.act = act; e.rd_chk = rd_chk;
        return e;
    endfunction

    // Per-cycle comparison against the behavioural model
    exp_t  ce;
    string ct;
    always @(negedge clk) begin
        if (run_chk) begin
            if (expq.size() != 0) begin
                ce = expq.pop_front();
                ct = tagq.pop_front();
            end else begin
                ce = mk({NB{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
                ct = "R10";
            end
            chk({mem_cs_n, mem_we_n, mem_oe_n, rsp_ready, rsp_error} ==
                {ce.cs_n, ce.we_n, ce.oe_n, ce.rdy, ce.err}, ct, "strobes",
                64'({mem_cs_n, mem_we_n, mem_oe_n, rsp_ready, rsp_error}),
                64'({ce.cs_n, ce.we_n, ce.oe_n, ce.rdy, ce.err}));
            if (ce.act) begin
                // R8: address, data and lanes held while selected
                chk({mem_addr, mem_be_n} == {cur_addr, cur_be_n}, "R8", "addr/be_n",
                    64'({mem_addr, mem_be_n}), 64'({cur_addr, cur_be_n}));
                if (cur_write)
                    chk(mem_wdata == cur_wdata, "R8", "wdata", 64'(mem_wdata), 64'(cur_wdata));
            end
            if (ce.rd_chk)
                chk(rsp_rdata == cur_rdata, "R4", "rdata", 64'(rsp_rdata), 64'(cur_rdata));
        end
    end

    task automatic wait_drain();
        while (expq.size() != 0) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
    endtask

    task automatic xfer(input int bank, input logic [AW-1:0] addr, input bit wr,
                        input logic [DW-1:0] wd, input logic [EW-1:0] be,
                        input logic [DW-1:0] rd, input string tag, input bit poke);
        bit illegal, err;
        int w;
        logic [NB-1:0] csv;
        illegal = cfg_page[bank] && cfg_xwait_en[bank];
        err = illegal || (wr && cfg_wprot[bank]);
        if (cfg_xwait_en[bank])
            w = (cfg_xwait_cnt == 0) ? 1 : int'(cfg_xwait_cnt) * 16;
        else if (wr)
            w = int'(cfg_wr_wait[bank*5 +: 5]) + 1;
        else
            w = int'(cfg_rd_wait[bank*5 +: 5]) + 1;
        csv = ~(NB'(1) << bank);
        cur_addr = addr; cur_wdata = wd; cur_write = wr; cur_rdata = rd;
        cur_be_n = wr ? ~be : '0;
        req_valid = 1'b1; req_bank = BW'(bank); req_addr = addr; req_write = wr;
        req_wdata = wd; req_be = be; mem_rdata = rd;
        if (err) begin
            expq.push_back(mk({NB{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0)); tagq.push_back(tag);
            expq.push_back(mk({NB{1'b1}}, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0)); tagq.push_back(tag);
        end else begin
            expq.push_back(mk(csv, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0)); tagq.push_back(tag);
            for (int i = 0; i < w; i++) begin
                expq.push_back(mk(csv, !wr, wr, 1'b0, 1'b0, 1'b1, 1'b0)); tagq.push_back(tag);
            end
            expq.push_back(mk(csv, 1'b1, wr, 1'b0, 1'b0, 1'b1, 1'b0)); tagq.push_back(tag);
            expq.push_back(mk({NB{1'b1}}, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, !wr)); tagq.push_back(tag);
        end
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (poke) begin
            // R9: a second request while busy must be ignored
            repeat (4) begin @(negedge clk); #1; end
            req_valid = 1'b1; req_bank = BW'(bank ^ 1); req_addr = ~addr;
            req_write = !wr; req_be = ~be; req_wdata = ~wd;
            @(negedge clk); #1;
            req_valid = 1'b0;
        end
        wait_drain();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // bank0: rd=2 wr=3 ; bank1: protected ; bank2: extended wait ; bank3: illegal
        cfg_rd_wait = {5'd0, 5'd5, 5'd0, 5'd2};
        cfg_wr_wait = {5'd0, 5'd7, 5'd0, 5'd3};
        cfg_wprot = 4'b0010;
        cfg_xwait_en = 4'b1100;
        cfg_page = 4'b1000;
        cfg_xwait_cnt = 10'd2;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk({mem_cs_n, mem_we_n, mem_oe_n, rsp_ready, rsp_error} == {{NB{1'b1}}, 4'b1100},
            "R1", "reset", 64'({mem_cs_n, mem_we_n, mem_oe_n, rsp_ready, rsp_error}),
            64'({{NB{1'b1}}, 4'b1100}));
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk({mem_cs_n, mem_we_n, mem_oe_n, rsp_ready, rsp_error} == {{NB{1'b1}}, 4'b1100},
            "R1", "after reset", 64'({mem_cs_n, mem_we_n, mem_oe_n, rsp_ready, rsp_error}),
            64'({{NB{1'b1}}, 4'b1100}));
        #1 run_chk = 1'b1;

        xfer(0, 16'h1234, 1'b0, 16'h0, 2'b11, 16'hA55A, "R2", 1'b0);   // R2 R4 read, 3 waits
        xfer(0, 16'h2001, 1'b1, 16'hBEEF, 2'b01, 16'h0, "R3", 1'b0);   // R3 write, 4 waits
        xfer(0, 16'h2002, 1'b0, 16'h0, 2'b11, 16'h0F0F, "R4", 1'b0);   // R4 another data pattern
        xfer(1, 16'h0040, 1'b1, 16'h1111, 2'b11, 16'h0, "R6", 1'b0);   // R6 protected write
        xfer(1, 16'h0044, 1'b0, 16'h0, 2'b11, 16'h7E81, "R6", 1'b0);   // R6 protected read ok
        xfer(2, 16'h0300, 1'b0, 16'h0, 2'b11, 16'hC3C3, "R5", 1'b0);   // R5 32 waits read
        xfer(2, 16'h0302, 1'b1, 16'h5A5A, 2'b10, 16'h0, "R5", 1'b0);   // R5 32 waits write
        xfer(3, 16'h0400, 1'b0, 16'h0, 2'b11, 16'h9999, "R7", 1'b0);   // R7 illegal read
        xfer(3, 16'h0402, 1'b1, 16'h4444, 2'b11, 16'h0, "R7", 1'b0);   // R7 illegal write

        cfg_rd_wait[4:0] = 5'd31;
        cfg_wr_wait[4:0] = 5'd0;
        xfer(0, 16'hFFFE, 1'b0, 16'h0, 2'b11, 16'h8001, "R2", 1'b0);   // R2 32 waits
        xfer(0, 16'h0010, 1'b1, 16'h6006, 2'b10, 16'h0, "R3", 1'b0);   // R3 1 wait
        xfer(0, 16'h0BAD, 1'b0, 16'h0, 2'b11, 16'h3C3C, "R9", 1'b1);   // R9 busy request ignored

        cfg_xwait_cnt = 10'd0;
        xfer(2, 16'h0500, 1'b0, 16'h0, 2'b11, 16'h1357, "R5", 1'b0);   // R5 zero field -> 1
        cfg_xwait_cnt = 10'd1023;
        xfer(2, 16'h0600, 1'b1, 16'h2468, 2'b11, 16'h0, "R5", 1'b0);   // R5 16368 waits
        xfer(2, 16'h0602, 1'b0, 16'h0, 2'b11, 16'hFACE, "R8", 1'b0);   // R8 bank2 select

        run_chk = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule